// File: doc/BRIEF.md
# Address-masked GPIO port controller

This block is a small general purpose I/O port of `PIN_W` pins (eight by default) on a simple register bus with separate read and write strobes. It holds two registers: a direction register, where a 1 makes a pin an output, and an output data register, which drives the pins. Each pin input passes through a multi-flop synchroniser before it can be read.

The data register is not reached at a single address. It occupies a window of addresses, and the address bits just above the byte offset form a per-pin mask. A read returns only the pins selected by the mask. A write changes only the selected pins. Software can therefore set, clear or test one pin with a single access, with no read-modify-write sequence and no race against other code that drives other pins.

Top module: `amgpio_port`

## Requirements
- R1: After reset the direction register and the output data register are zero, so `pin_oe` and `pin_out` are all zero and a read of the direction offset returns 0.
- R2: A write to the data window (offsets below 0x400, aligned to four bytes) updates each output bit whose mask bit `bus_addr[9:2]` is 1 from `bus_wdata`, and leaves each bit whose mask bit is 0 unchanged. `pin_out` shows the output register.
- R3: Writing data `1<<n` to offset `1<<(n+2)` sets pin n alone, and writing 0 to that offset clears pin n alone.
- R4: A read of the data window returns 0 on every bit whose mask bit `bus_addr[9:2]` is 0.
- R5: On a data read with mask bit 1, an output pin (direction bit 1) returns its output register bit and an input pin (direction bit 0) returns its synchronised input.
- R6: Offset 0x400 holds the direction register. A write sets it from `bus_wdata`, `pin_oe` shows it, and a read returns it.
- R7: A change on `pin_in` reaches the read path after exactly two rising clock edges: it is not visible after one edge and is visible after two.
- R8: Any other offset, including a data window offset whose low two address bits are not zero, reads as 0, and a write there changes neither `pin_out` nor `pin_oe`.
- R9: `bus_rdata` is 0 whenever `bus_rd` is low.
- R10: When a read and a write to the same offset happen in the same cycle, the read returns the value held before the write, and the write takes effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wdata | input | PIN_W (8) | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle it is high |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_rdata | output | PIN_W (8) | Read data, zero when no read is strobed |
| pin_in | input | PIN_W (8) | Asynchronous pin inputs |
| pin_out | output | PIN_W (8) | Pin output values (output data register) |
| pin_oe | output | PIN_W (8) | Pin output enables (direction register) |

## Verification
A read and a write can hit the data register in the same cycle. The read path is combinational from the registers, so it must show the pre-write value while the write lands at the edge. The bench raises both strobes on one full-mask data address with new write data. It then checks that the read data in that cycle matches the old output bits merged with the synchronised inputs, and that after the edge both the read data and `pin_out` carry the new bits on output pins only. A second overlap, an input pin changing while a read is held, is judged by sampling the held read one edge and two edges after the change.

// File: rtl/amgpio_pkg.sv
package amgpio_pkg;

   // Register region selected by an access address.
   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_DATA = 2'd1,
      RGN_DIR  = 2'd2
   } amgpio_rgn_e;

endpackage

// File: rtl/amgpio_decode.sv
module amgpio_decode
   import amgpio_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int PIN_W    = 8,
   parameter int MASK_LSB = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output amgpio_rgn_e       rgn,
   output logic [PIN_W-1:0]  mask
);

   localparam int              WIN_BITS = MASK_LSB + PIN_W;
   localparam logic [ADDR_W-1:0] DIR_OFF = ADDR_W'(1) << WIN_BITS;

   logic aligned;
   logic in_window;
   logic at_dir;

   // Alignment check only exists when there are byte-offset bits below the mask.
   generate
      if (MASK_LSB > 0) begin : g_align
         assign aligned = (addr[MASK_LSB-1:0] == '0);
      end else begin : g_noalign
         assign aligned = 1'b1;
      end
   endgenerate

   assign in_window = (addr[ADDR_W-1:WIN_BITS] == '0);
   assign at_dir    = (addr[ADDR_W-1:MASK_LSB] == DIR_OFF[ADDR_W-1:MASK_LSB]);
   assign mask      = addr[MASK_LSB +: PIN_W];

   always_comb begin
      rgn = RGN_NONE;
      if (aligned && in_window) rgn = RGN_DATA;
      else if (aligned && at_dir) rgn = RGN_DIR;
   end

endmodule

// File: rtl/amgpio_sync.sv
module amgpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         for (int i = STAGES - 1; i > 0; i--) stg[i] <= stg[i-1];
         stg[0] <= d;
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/amgpio_regs.sv
module amgpio_regs #(
   parameter int PIN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             data_we,
   input  logic             dir_we,
   input  logic [PIN_W-1:0] mask,
   input  logic [PIN_W-1:0] wdata,
   output logic [PIN_W-1:0] out_q,
   output logic [PIN_W-1:0] dir_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         dir_q <= '0;
      end else begin
         if (data_we) out_q <= (out_q & ~mask) | (wdata & mask);
         if (dir_we)  dir_q <= wdata;
      end
   end

endmodule

// File: rtl/amgpio_port.sv
module amgpio_port
   import amgpio_pkg::*;
#(
   parameter int PIN_W       = 8,
   parameter int MASK_LSB    = 2,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [PIN_W-1:0]  bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [PIN_W-1:0]  bus_rdata,
   input  logic [PIN_W-1:0]  pin_in,
   output logic [PIN_W-1:0]  pin_out,
   output logic [PIN_W-1:0]  pin_oe
);

   // Elaboration-time parameter checks.
   generate
      if (PIN_W < 1) begin : g_bad_pins
         $error("amgpio_port: PIN_W must be at least 1");
      end
      if (ADDR_W < MASK_LSB + PIN_W + 1) begin : g_bad_addr
         $error("amgpio_port: ADDR_W too narrow for data window plus direction offset");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("amgpio_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   amgpio_rgn_e      rgn;
   logic [PIN_W-1:0] mask;
   logic [PIN_W-1:0] out_q;
   logic [PIN_W-1:0] dir_q;
   logic [PIN_W-1:0] in_sync;
   logic [PIN_W-1:0] pin_val;

   amgpio_decode #(
      .ADDR_W  (ADDR_W),
      .PIN_W   (PIN_W),
      .MASK_LSB(MASK_LSB)
   ) u_dec (
      .addr(bus_addr),
      .rgn (rgn),
      .mask(mask)
   );

   amgpio_sync #(
      .W     (PIN_W),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_in),
      .q    (in_sync)
   );

   amgpio_regs #(
      .PIN_W(PIN_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .data_we(bus_wr && (rgn == RGN_DATA)),
      .dir_we (bus_wr && (rgn == RGN_DIR)),
      .mask   (mask),
      .wdata  (bus_wdata),
      .out_q  (out_q),
      .dir_q  (dir_q)
   );

   // Output pins read back the driven value, input pins the synchronised level.
   assign pin_val = (dir_q & out_q) | (~dir_q & in_sync);

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         unique case (rgn)
            RGN_DATA: bus_rdata = pin_val & mask;
            RGN_DIR:  bus_rdata = dir_q;
            default:  bus_rdata = '0;
         endcase
      end
   end

   assign pin_out = out_q;
   assign pin_oe  = dir_q;

endmodule

// File: rtl/amgpio_port_chk.sv
module amgpio_port_chk #(
   parameter int PIN_W    = 8,
   parameter int MASK_LSB = 2,
   parameter int ADDR_W   = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [PIN_W-1:0]  bus_wdata,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [PIN_W-1:0]  bus_rdata,
   input logic [PIN_W-1:0]  pin_out,
   input logic [PIN_W-1:0]  pin_oe
);

   localparam logic [ADDR_W-1:0] DIR_OFF  = ADDR_W'(1) << (MASK_LSB + PIN_W);
   localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << MASK_LSB) - 1);

   logic             ck_aligned;
   logic             ck_data;
   logic             ck_dir;
   logic [PIN_W-1:0] ck_mask;

   assign ck_aligned = ((bus_addr & LOW_MASK) == '0);
   assign ck_data    = ck_aligned && (bus_addr < DIR_OFF);
   assign ck_dir     = (bus_addr == DIR_OFF);
   assign ck_mask    = bus_addr[MASK_LSB +: PIN_W];

   // R1: a reset cycle leaves both registers cleared
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (pin_oe == '0 && pin_out == '0));

   // R2: selected bits take the write data
   a_r2_masked_take: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && ck_data) |=>
         ((pin_out & $past(ck_mask)) == ($past(bus_wdata) & $past(ck_mask))));

   // R2: unselected bits keep their value
   a_r2_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && ck_data) |=>
         ((pin_out & ~$past(ck_mask)) == ($past(pin_out) & ~$past(ck_mask))));

   // R4: unselected bits read as zero
   a_r4_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && ck_data) |-> ((bus_rdata & ~ck_mask) == '0));

   // R6: direction write lands in the output enables
   a_r6_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && ck_dir) |=> (pin_oe == $past(bus_wdata)));

   // R8: writes outside the map change nothing
   a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !ck_data && !ck_dir) |=> ($stable(pin_out) && $stable(pin_oe)));

   // R9: idle read data is zero
   a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == '0));

endmodule

bind amgpio_port amgpio_port_chk #(
   .PIN_W   (PIN_W),
   .MASK_LSB(MASK_LSB),
   .ADDR_W  (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_wr   (bus_wr),
   .bus_rd   (bus_rd),
   .bus_rdata(bus_rdata),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe)
);

// File: tb/amgpio_port_test.sv
`timescale 1ns/1ps
module amgpio_port_test;

   localparam int PIN_W  = 8;
   localparam int ADDR_W = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [PIN_W-1:0]  bus_wdata = '0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [PIN_W-1:0]  bus_rdata;
   logic [PIN_W-1:0]  pin_in = '0;
   logic [PIN_W-1:0]  pin_out;
   logic [PIN_W-1:0]  pin_oe;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   amgpio_port uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_wr   (bus_wr),
      .bus_rd   (bus_rd),
      .bus_rdata(bus_rdata),
      .pin_in   (pin_in),
      .pin_out  (pin_out),
      .pin_oe   (pin_oe)
   );

   task automatic check(input string req, input logic [PIN_W-1:0] got,
                        input logic [PIN_W-1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [PIN_W-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [PIN_W-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic t_reset();
      logic [PIN_W-1:0] r;
      check("R1 pin_oe after reset", pin_oe, 8'h00);
      check("R1 pin_out after reset", pin_out, 8'h00);
      bus_read(12'h400, r);
      check("R1 direction read after reset", r, 8'h00);
   endtask

   task automatic t_masked_write();
      bus_write(12'h3FC, 8'hA5);
      check("R2 full-mask write", pin_out, 8'hA5);
      bus_write(12'h03C, 8'h5A);
      check("R2 low-nibble mask write", pin_out, 8'hAA);
      bus_write(12'h000, 8'hFF);
      check("R2 empty-mask write", pin_out, 8'hAA);
   endtask

   task automatic t_set_clear();
      bus_write(12'h004, 8'h01);
      check("R3 set pin 0", pin_out, 8'hAB);
      bus_write(12'h200, 8'h00);
      check("R3 clear pin 7", pin_out, 8'h2B);
      bus_write(12'h040, 8'h10);
      check("R3 set pin 4", pin_out, 8'h3B);
   endtask

   task automatic t_dir();
      logic [PIN_W-1:0] r;
      bus_write(12'h400, 8'hF0);
      check("R6 pin_oe after direction write", pin_oe, 8'hF0);
      bus_read(12'h400, r);
      check("R6 direction read back", r, 8'hF0);
   endtask

   task automatic t_read_source();
      logic [PIN_W-1:0] r;
      @(negedge clk);
      pin_in = 8'h5C;
      repeat (3) @(negedge clk);
      bus_read(12'h3FC, r);
      check("R5 mixed direction read", r, 8'h3C);
   endtask

   task automatic t_masked_read();
      logic [PIN_W-1:0] r;
      bus_read(12'h090, r);
      check("R4 mask 0x24 read", r, 8'h24);
      bus_read(12'h000, r);
      check("R4 empty-mask read", r, 8'h00);
      bus_read(12'h060, r);
      check("R4 mask 0x18 read", r, 8'h18);
   endtask

   task automatic t_sync();
      @(negedge clk);
      bus_addr = 12'h03C; bus_rd = 1'b1;
      pin_in = 8'h53;
      @(negedge clk);
      check("R7 input after one edge", bus_rdata, 8'h0C);
      @(negedge clk);
      check("R7 input after two edges", bus_rdata, 8'h03);
      bus_rd = 1'b0;
   endtask

   task automatic t_unmapped();
      logic [PIN_W-1:0] r;
      bus_write(12'h404, 8'hFF);
      check("R8 write 0x404 pin_oe", pin_oe, 8'hF0);
      check("R8 write 0x404 pin_out", pin_out, 8'h3B);
      bus_write(12'h3FD, 8'h00);
      check("R8 misaligned write pin_out", pin_out, 8'h3B);
      bus_read(12'h800, r);
      check("R8 read 0x800", r, 8'h00);
      bus_read(12'h3FE, r);
      check("R8 misaligned read", r, 8'h00);
   endtask

   task automatic t_idle();
      @(negedge clk);
      bus_addr = 12'h3FC; bus_rd = 1'b0;
      #1 check("R9 rdata with no read strobe", bus_rdata, 8'h00);
   endtask

   task automatic t_same_cycle();
      @(negedge clk);
      bus_addr = 12'h3FC; bus_wdata = 8'hC5; bus_wr = 1'b1; bus_rd = 1'b1;
      #1 check("R10 read during write shows old value", bus_rdata, 8'h33);
      @(negedge clk);
      bus_wr = 1'b0;
      #1 check("R10 read after write edge", bus_rdata, 8'hC3);
      check("R10 pin_out after write edge", pin_out, 8'hC5);
      bus_rd = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_masked_write();
      t_set_clear();
      t_dir();
      t_read_source();
      t_masked_read();
      t_sync();
      t_unmapped();
      t_idle();
      t_same_cycle();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule